// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block takes a frequency tuning word that arrives over a three-wire serial link (clock, data and a start strobe) and hands it to the synthesizer clock domain as a 48-bit word. Software picks the word length in whole bytes, from one to five. The received bits are packed toward the top of the 48-bit word, first bit in the most significant position, and every bit below them reads zero.

A transfer is one start-strobe clock, then 8×N data clocks, then two more serial clocks. On the first of those two clocks the packed word goes into a holding register in the serial domain. On the second, a toggle flag flips. A two-flop synchronizer carries that flag into the synthesizer domain, where its edge captures the holding register and raises a one-cycle strobe. An enable input, driven from a parallel control bit, forces the delivered word to zero while low. It does not disturb the stored word.

Top module: `ser_tuning_loader`

## Requirements
- R1: `bytes_cfg` is latched on the start-strobe edge and sets the word length to 8×N bits. Values 1 to 5 give N directly, 0 gives N=1 and values above 5 give N=5.
- R2: Data is taken on rising `ser_clk`, first bit first. The first data bit lands in bit 47 and the 8×N received bits fill bits 47 down to 48−8N. All lower bits are zero.
- R3: The word is delivered only after two further rising `ser_clk` edges follow the last data bit. `freq_word` updates and `word_strobe` is high on the third rising `dds_clk` edge after the second of those edges.
- R4: `word_strobe` is high for exactly one `dds_clk` cycle per delivered word.
- R5: While `enable` is 0, `freq_word` is all zeros. The stored word is kept, and raising `enable` again shows the last delivered word.
- R6: A start strobe in the middle of a word, or before its two transfer edges, discards the partial word and restarts the bit count. The previously delivered word stays on the output.
- R7: The data bit present on the start-strobe edge is ignored. Serial edges that come before any start strobe, or after a transfer completes, change nothing.
- R8: A change of `bytes_cfg` after the start strobe has no effect on the word that is being received.
- R9: After reset, `word_strobe` is 0. The stored word holds its value until the first complete word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, first bit first |
| ser_sync | input | 1 | Start strobe, high for one serial clock |
| bytes_cfg | input | 3 | Word length in bytes |
| dds_clk | input | 1 | Synthesizer clock |
| enable | input | 1 | Gates the delivered word |
| freq_word | output | 48 | Delivered tuning word |
| word_strobe | output | 1 | One-cycle pulse when a new word is captured |

## Verification
The bench covers every length setting, including the clamped codes 0 and 7. A design that ignored the clamp, or packed bits from the wrong end, would produce a shifted or truncated word. Start strobes are placed in mid-word and between the last data bit and the transfer edges. A design that failed to abort would deliver a stale mix of bits or a spurious strobe. The bench also flips `bytes_cfg` during reception, drives a one on the strobe edge and clocks before any strobe, which exposes a length that is sampled late or data that is taken on the wrong edge. An independent model predicts the exact synthesizer cycle of each capture, so any added or missing synchronizer stage shows up as a miscompare.

// File: rtl/ser_tuning_loader.sv
module ser_tuning_loader #(
  parameter int WORD_W    = 48,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 5,
  parameter int CFG_W     = 3
) (
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_sync,
  input  logic [CFG_W-1:0]  bytes_cfg,
  input  logic              dds_clk,
  input  logic              enable,
  output logic [WORD_W-1:0] freq_word,
  output logic              word_strobe
);
  localparam int CNT_W = $clog2(BYTE_W*MAX_BYTES+1);
  localparam int LOW_W = WORD_W - BYTE_W*MAX_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_LATCH, S_FLAG} st_t;

  st_t               state;
  logic [CNT_W-1:0]  bcnt;
  logic [CFG_W-1:0]  nlat;
  logic [WORD_W-1:0] sr, hold, freq_reg;
  logic              tog, sync1, sync2, sync3, stb_q;

  wire [CFG_W-1:0] n_clamped = (bytes_cfg == '0) ? CFG_W'(1) :
                               (int'(bytes_cfg) > MAX_BYTES) ? CFG_W'(MAX_BYTES) : bytes_cfg;
  wire [CNT_W-1:0] last_bit  = CNT_W'(BYTE_W*int'(nlat) - 1);

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bcnt  <= '0;
      nlat  <= CFG_W'(1);
      sr    <= '0;
      hold  <= '0;
      tog   <= 1'b0;
    end else if (ser_sync) begin
      state <= S_RECV;
      bcnt  <= '0;
      nlat  <= n_clamped;
      sr    <= '0;
    end else begin
      case (state)
        S_RECV: begin
          sr   <= {sr[WORD_W-2:0], ser_data};
          bcnt <= bcnt + 1'b1;
          if (bcnt == last_bit) state <= S_LATCH;
        end
        S_LATCH: begin
          hold  <= sr << (WORD_W - BYTE_W*int'(nlat));
          state <= S_FLAG;
        end
        S_FLAG: begin
          tog   <= ~tog;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge dds_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      sync1 <= tog;
      sync2 <= sync1;
      sync3 <= sync2;
      stb_q <= sync2 ^ sync3;
    end
  end

  always_ff @(posedge dds_clk) begin
    if (sync2 ^ sync3) freq_reg <= hold;
  end

  assign word_strobe = stb_q;
  assign freq_word   = enable ? freq_reg : '0;

  AST_SYNC_RESTART: assert property (@(posedge ser_clk) disable iff (!rst_n)
    ser_sync |=> (state == S_RECV && bcnt == '0)); // R6
  AST_LEN_RANGE: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (state == S_RECV) |-> (int'(nlat) >= 1 && int'(nlat) <= MAX_BYTES && int'(bcnt) < BYTE_W*int'(nlat))); // R1
  AST_XFER_SEQ: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (state == S_LATCH && !ser_sync) |=> (state == S_FLAG)); // R3
  AST_LOW_ZERO: assert property (@(posedge dds_clk) disable iff (!rst_n)
    word_strobe |-> (freq_reg[LOW_W-1:0] == '0)); // R2
  AST_STROBE_ONE: assert property (@(posedge dds_clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe); // R4
endmodule

// File: tb/sim_ser_tuning_loader.sv
module sim_ser_tuning_loader;
  logic        rst_n = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_sync = 1'b0;
  logic [2:0]  bytes_cfg = 3'd1;
  logic        dds_clk = 1'b0, enable = 1'b0;
  logic [47:0] freq_word;
  logic        word_strobe;

  int vectors = 0, errors = 0;
  string cur_req = "R9";

  ser_tuning_loader u0 (.rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync),
    .bytes_cfg(bytes_cfg), .dds_clk(dds_clk), .enable(enable), .freq_word(freq_word),
    .word_strobe(word_strobe));

  always #10 dds_clk = ~dds_clk;

  // behavioural reference model
  int          m_phase = 0;
  int          m_n = 1;
  bit          m_bits[$];
  logic [47:0] m_pend_word = '0;
  int          pend_cnt = 0;
  logic [47:0] exp_word = '0;
  bit          exp_known = 0, exp_stb = 0;

  task automatic model_edge();
    if (ser_sync) begin
      m_phase = 1;
      m_bits.delete();
      m_n = (bytes_cfg == 0) ? 1 : (bytes_cfg > 5) ? 5 : int'(bytes_cfg);
    end else if (m_phase == 1) begin
      m_bits.push_back(ser_data);
      if (m_bits.size() == 8*m_n) m_phase = 2;
    end else if (m_phase == 2) begin
      m_pend_word = '0;
      for (int i = 0; i < m_bits.size(); i++) m_pend_word[47-i] = m_bits[i];
      m_phase = 3;
    end else if (m_phase == 3) begin
      pend_cnt = 3;
      m_phase = 0;
    end
  endtask

  always @(posedge dds_clk) begin
    #1;
    exp_stb = 0;
    if (rst_n && pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        exp_word = m_pend_word;
        exp_known = 1;
        exp_stb = 1;
      end
    end
  end

  always @(negedge dds_clk) begin
    if (rst_n) begin
      vectors++;
      if (word_strobe !== exp_stb) begin
        errors++;
        $display("FAIL %s strobe actual=%b expected=%b t=%0t", cur_req, word_strobe, exp_stb, $time);
      end
      if (!enable || exp_known) begin
        vectors++;
        if (freq_word !== (enable ? exp_word : 48'h0)) begin
          errors++;
          $display("FAIL %s word actual=%h expected=%h t=%0t", cur_req, freq_word,
                   enable ? exp_word : 48'h0, $time);
        end
      end
    end
  end

  task automatic edge_(input logic s, input logic d);
    ser_sync = s; ser_data = d;
    @(posedge dds_clk); #5 ser_clk = 1'b1;
    model_edge();
    @(posedge dds_clk); #5 ser_clk = 1'b0;
  endtask

  task automatic send(input logic [2:0] cfg, input logic [39:0] val, input int nbits, input int extra);
    bytes_cfg = cfg;
    edge_(1'b1, 1'b0);
    for (int i = 0; i < nbits; i++) edge_(1'b0, val[39-i]);
    for (int i = 0; i < extra; i++) edge_(1'b0, 1'b0);
  endtask

  task automatic settle();
    repeat (6) @(posedge dds_clk);
  endtask

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge dds_clk);
    #3 rst_n = 1'b1;
    @(negedge dds_clk);
    chk("R9", {47'b0, word_strobe}, 48'h0);
    cur_req = "R7";
    for (int i = 0; i < 4; i++) edge_(1'b0, 1'b1);
    settle();
    cur_req = "R1";
    send(3'd1, 40'hA5_0000_0000, 8, 2); settle();
    enable = 1'b1;
    @(negedge dds_clk); chk("R2", freq_word, 48'hA5_0000_0000_00);
    cur_req = "R2";
    send(3'd5, 40'h12_3456_789A, 40, 2); settle();
    @(negedge dds_clk); chk("R2", freq_word, 48'h12_3456_789A_00);
    cur_req = "R3";
    send(3'd2, 40'hBEEF_000000, 16, 2); settle();
    send(3'd3, 40'hC0FFEE_0000, 24, 2); settle();
    send(3'd4, 40'hDEADBEEF_00, 32, 2); settle();
    @(negedge dds_clk); chk("R3", freq_word, 48'hDEAD_BEEF_0000);
    cur_req = "R1";
    send(3'd0, 40'h3C_0000_0000, 8, 2); settle();
    @(negedge dds_clk); chk("R1", freq_word, 48'h3C00_0000_0000);
    send(3'd7, 40'hFF_0102_0304, 40, 2); settle();
    @(negedge dds_clk); chk("R1", freq_word, 48'hFF01_0203_0400);
    cur_req = "R6";
    send(3'd2, 40'hAAAA_000000, 12, 0);
    send(3'd1, 40'h5A_0000_0000, 8, 1);
    send(3'd1, 40'h77_0000_0000, 8, 0);
    settle();
    @(negedge dds_clk); chk("R6", freq_word, 48'hFF01_0203_0400);
    send(3'd1, 40'h69_0000_0000, 8, 2); settle();
    @(negedge dds_clk); chk("R6", freq_word, 48'h6900_0000_0000);
    cur_req = "R7";
    bytes_cfg = 3'd1;
    edge_(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) edge_(1'b0, 1'b0);
    edge_(1'b0, 1'b1); edge_(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) edge_(1'b0, 1'b1);
    settle();
    @(negedge dds_clk); chk("R7", freq_word, 48'h0);
    cur_req = "R8";
    bytes_cfg = 3'd1;
    edge_(1'b1, 1'b0);
    bytes_cfg = 3'd5;
    for (int i = 0; i < 8; i++) edge_(1'b0, i[0]);
    edge_(1'b0, 1'b0); edge_(1'b0, 1'b0);
    settle();
    @(negedge dds_clk); chk("R8", freq_word, 48'h5500_0000_0000);
    cur_req = "R5";
    enable = 1'b0;
    @(negedge dds_clk); chk("R5", freq_word, 48'h0);
    send(3'd2, 40'h1234_000000, 16, 2); settle();
    @(negedge dds_clk); chk("R5", freq_word, 48'h0);
    enable = 1'b1;
    @(negedge dds_clk); chk("R5", freq_word, 48'h1234_0000_0000);
    cur_req = "R4";
    settle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule